// File: doc/BRIEF.md
# Conditional Branch and Loop Unit

This block resolves the branch-family instructions of a 32-bit processor in one registered step. Each cycle that `in_valid_i` is high it takes an opcode word, the 16-bit word that follows it, the opcode's address, the four condition flags, the low word of the selected data register and the stack pointer. One cycle later it reports four things:
- the address of the next instruction;
- whether control was transferred;
- any new counter value for the data register;
- any stack push for a subroutine call.

Four kinds of instruction are handled. Plain conditional branches test one of fourteen flag conditions. There is an always-taken form and a call form that pushes a return address. The fourth kind is a counted loop instruction: it decrements a 16-bit counter when its exit condition is false, and it stops looping once the counter wraps to minus one. A short branch carries an 8-bit displacement. When that field is zero, the 16-bit displacement is read from the word after the opcode, and the fall-through and return addresses skip that word.

Top module: `branch_unit`

## Requirements
- R1: `flags_i` is {N,Z,V,C} (bit 3 to bit 0). The condition codes are:
  - 0000 true and 0001 false (loop form only).
  - 0010 HI: C|Z==0. 0011 LS: C|Z==1.
  - 0100: C==0. 0101: C==1.
  - 0110: Z==0. 0111: Z==1.
  - 1000: V==0. 1001: V==1.
  - 1010: N==0. 1011: N==1.
  - 1100 GE: N^V==0. 1101 LT: N^V==1.
  - 1110 GT: Z|(N^V)==0. 1111 LE: Z|(N^V)==1.
- R2: A branch opcode has bits [15:12]=0110, a condition in [11:8] and an 8-bit displacement d8 in [7:0]. When d8 is nonzero and the branch is taken, the next PC is op_addr+2+sign-extended d8.
- R3: When d8 is zero, the displacement is the sign-extended 16-bit extension word. The not-taken next PC is then op_addr+4.
- R4: Condition 0000 in a branch opcode is always taken.
- R5: Condition 0001 in a branch opcode is a subroutine call. It is always taken and raises `push_req_o`, with `push_addr_o`=sp−4 and `push_data_o` equal to the address after the opcode and any extension word.
- R6: A conditional branch whose condition is false is not taken. Its next PC is op_addr+2, or op_addr+4 when d8 is zero.
- R7: The loop opcode has bits [15:12]=0101, a condition in [11:8] and bits [7:3]=11001, and it always uses the extension word. When its condition is false, it writes counter−1 to the low word. It is taken to op_addr+2+sign-extended extension unless the new value is 0xFFFF; in that case the next PC is op_addr+4.
- R8: When the loop condition is true, the counter is not written, nothing is taken, and the next PC is op_addr+4.
- R9: Any other opcode reports `is_branch_o`=0, not taken, next PC op_addr+2, and no register write or push.
- R10: Results appear the cycle after `in_valid_i`, flagged by `out_valid_o`. After reset, or after a cycle without `in_valid_i`, the taken, write and push strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 16 | Opcode word |
| ext_i | input | 16 | Word following the opcode |
| op_addr_i | input | XLEN | Address of the opcode |
| flags_i | input | 4 | {N,Z,V,C} |
| dcount_i | input | 16 | Low word of selected data register |
| sp_i | input | XLEN | Stack pointer |
| out_valid_o | output | 1 | Result valid |
| is_branch_o | output | 1 | Opcode belongs to the branch family |
| taken_o | output | 1 | Control transferred |
| next_pc_o | output | XLEN | Next instruction address |
| dreg_we_o | output | 1 | Write `dcount_o` to register low word |
| dcount_o | output | 16 | New counter low word |
| push_req_o | output | 1 | Stack push request |
| push_addr_o | output | XLEN | Push address (sp−4) |
| push_data_o | output | XLEN | Return address to push |

## Verification
The assertions check every cycle that:
- the result strobe trails the input strobe by exactly one cycle;
- the write and push strobes are never both high;
- a written counter is one less than its input, and a wrap to 0xFFFF never loops;
- push address and return data follow the stack pointer and opcode address;
- a not-taken result lands two or four bytes past the opcode.

Only the bench scenarios can show the rest:
- that each condition code decodes to the right flag test;
- that a zero short displacement really selects the extension word;
- the exact taken targets;
- that a true loop condition or a non-branch opcode leaves the counter untouched.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  input  logic [15:0]     opcode_i,
  input  logic [15:0]     ext_i,
  input  logic [XLEN-1:0] op_addr_i,
  input  logic [3:0]      flags_i,
  input  logic [15:0]     dcount_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            out_valid_o,
  output logic            is_branch_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            dreg_we_o,
  output logic [15:0]     dcount_o,
  output logic            push_req_o,
  output logic [XLEN-1:0] push_addr_o,
  output logic [XLEN-1:0] push_data_o
);

  function automatic logic cond_met(input logic [3:0] code, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (code[3:1])
      3'd0:    cond_met = 1'b1;
      3'd1:    cond_met = ~(c | z);
      3'd2:    cond_met = ~c;
      3'd3:    cond_met = ~z;
      3'd4:    cond_met = ~v;
      3'd5:    cond_met = ~n;
      3'd6:    cond_met = ~(n ^ v);
      default: cond_met = ~(z | (n ^ v));
    endcase
    cond_met = cond_met ^ code[0];
  endfunction

  wire [3:0] cc      = opcode_i[11:8];
  wire       is_bcc  = opcode_i[15:12] == 4'b0110;
  wire       is_loop = opcode_i[15:12] == 4'b0101 && opcode_i[7:3] == 5'b11001;
  wire       use_ext = is_loop || (is_bcc && opcode_i[7:0] == 8'd0);
  wire       is_call = is_bcc && cc == 4'b0001;
  wire       cond    = cond_met(cc, flags_i);

  wire [XLEN-1:0] disp   = use_ext ? {{(XLEN-16){ext_i[15]}}, ext_i}
                                   : {{(XLEN-8){opcode_i[7]}}, opcode_i[7:0]};
  wire [XLEN-1:0] upd_pc = op_addr_i + XLEN'(2);
  wire [XLEN-1:0] seq_pc = upd_pc + (use_ext ? XLEN'(2) : XLEN'(0));
  wire [XLEN-1:0] target = upd_pc + disp;

  wire [15:0] dec      = dcount_i - 16'd1;
  wire        loop_dec = is_loop && !cond;
  wire        take     = (is_bcc && (cond || is_call)) || (loop_dec && dec != 16'hFFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      is_branch_o <= 1'b0;
      taken_o     <= 1'b0;
      dreg_we_o   <= 1'b0;
      push_req_o  <= 1'b0;
      next_pc_o   <= '0;
      dcount_o    <= '0;
      push_addr_o <= '0;
      push_data_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      is_branch_o <= in_valid_i && (is_bcc || is_loop);
      taken_o     <= in_valid_i && take;
      dreg_we_o   <= in_valid_i && loop_dec;
      push_req_o  <= in_valid_i && is_call;
      next_pc_o   <= take ? target : seq_pc;
      dcount_o    <= dec;
      push_addr_o <= sp_i - XLEN'(4);
      push_data_o <= seq_pc;
    end
  end

endmodule

module branch_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid_i,
  input logic [XLEN-1:0] op_addr_i,
  input logic [15:0]     dcount_i,
  input logic [XLEN-1:0] sp_i,
  input logic            out_valid_o,
  input logic            taken_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            dreg_we_o,
  input logic [15:0]     dcount_o,
  input logic            push_req_o,
  input logic [XLEN-1:0] push_addr_o,
  input logic [XLEN-1:0] push_data_o
);

  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> out_valid_o == $past(in_valid_i));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> !taken_o && !dreg_we_o && !push_req_o);

  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_req_o, dreg_we_o}));

  a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o |-> taken_o && push_addr_o == $past(sp_i) - XLEN'(4));

  a_r5_push_data: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o |-> (push_data_o == $past(op_addr_i) + XLEN'(2) ||
                    push_data_o == $past(op_addr_i) + XLEN'(4)));

  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    dreg_we_o |-> dcount_o == $past(dcount_i) - 16'd1);

  a_r7_exit_at_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dreg_we_o && dcount_o == 16'hFFFF) |-> !taken_o);

  a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !taken_o) |-> (next_pc_o == $past(op_addr_i) + XLEN'(2) ||
                                   next_pc_o == $past(op_addr_i) + XLEN'(4)));

endmodule

bind branch_unit branch_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_addr_i(op_addr_i),
  .dcount_i(dcount_i), .sp_i(sp_i), .out_valid_o(out_valid_o), .taken_o(taken_o),
  .next_pc_o(next_pc_o), .dreg_we_o(dreg_we_o), .dcount_o(dcount_o),
  .push_req_o(push_req_o), .push_addr_o(push_addr_o), .push_data_o(push_data_o)
);

// File: tb/branch_unit_test.sv
module branch_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid;
  logic [15:0] opcode, ext, dcount;
  logic [31:0] op_addr, sp;
  logic [3:0]  flags;
  logic        out_valid, is_branch, taken, dreg_we, push_req;
  logic [31:0] next_pc, push_addr, push_data;
  logic [15:0] dcount_n;

  branch_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .opcode_i(opcode), .ext_i(ext),
    .op_addr_i(op_addr), .flags_i(flags), .dcount_i(dcount), .sp_i(sp),
    .out_valid_o(out_valid), .is_branch_o(is_branch), .taken_o(taken),
    .next_pc_o(next_pc), .dreg_we_o(dreg_we), .dcount_o(dcount_n),
    .push_req_o(push_req), .push_addr_o(push_addr), .push_data_o(push_data)
  );

  int tests = 0, fails = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (cc)
      4'h0: return 1'b1;   4'h1: return 1'b0;
      4'h2: return !c && !z; 4'h3: return c || z;
      4'h4: return !c;     4'h5: return c;
      4'h6: return !z;     4'h7: return z;
      4'h8: return !v;     4'h9: return v;
      4'hA: return !n;     4'hB: return n;
      4'hC: return n == v; 4'hD: return n != v;
      4'hE: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic apply(input logic [15:0] op, input logic [15:0] ew, input logic [31:0] pc,
                       input logic [3:0] f, input logic [15:0] dc, input logic [31:0] s,
                       input string ctag);
    logic bcc, lp, ex, e_take, e_we, e_push;
    logic [31:0] e_next, e_seq, tgt;
    logic [15:0] e_dc;
    string tag;
    opcode = op; ext = ew; op_addr = pc; flags = f; dcount = dc; sp = s; in_valid = 1'b1;
    bcc = op[15:12] == 4'h6;
    lp  = op[15:12] == 4'h5 && op[7:3] == 5'b11001;
    ex  = lp || (bcc && op[7:0] == 8'h00);
    e_seq = pc + (ex ? 32'd4 : 32'd2);
    tgt = pc + 32'd2 + (ex ? {{16{ew[15]}}, ew} : {{24{op[7]}}, op[7:0]});
    e_dc = dc - 16'd1;
    e_we = lp && !ref_cond(op[11:8], f);
    e_push = bcc && op[11:8] == 4'h1;
    if (bcc) e_take = op[11:8] == 4'h0 || e_push || ref_cond(op[11:8], f);
    else     e_take = e_we && e_dc != 16'hFFFF;
    e_next = e_take ? tgt : e_seq;
    if (ctag != "") tag = ctag;
    else if (!bcc && !lp) tag = "R9";
    else if (lp) tag = e_we ? "R7" : "R8";
    else if (e_push) tag = "R5";
    else if (op[11:8] == 4'h0) tag = "R4";
    else if (!e_take) tag = "R6";
    else if (ex) tag = "R3";
    else tag = "R2";
    @(negedge clk);
    chk("R10", "out_valid", 32'(out_valid), 32'd1);
    chk("R9", "is_branch", 32'(is_branch), 32'(bcc || lp));
    chk(tag, "taken", 32'(taken), 32'(e_take));
    chk(tag, "next_pc", next_pc, e_next);
    chk(lp ? (e_we ? "R7" : "R8") : "R9", "dreg_we", 32'(dreg_we), 32'(e_we));
    if (e_we) chk("R7", "dcount", 32'(dcount_n), 32'(e_dc));
    chk("R5", "push_req", 32'(push_req), 32'(e_push));
    if (e_push) begin
      chk("R5", "push_addr", push_addr, s - 32'd4);
      chk("R5", "push_data", push_data, e_seq);
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; ext = '0; op_addr = '0;
    flags = '0; dcount = '0; sp = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R10", "reset taken", 32'(taken), 32'd0);
    chk("R10", "reset push", 32'(push_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(16'h6EFA, 16'h0, 32'h1004, 4'h0, 16'h0, 32'h8000, "R2");
    apply(16'h6600, 16'hFF00, 32'h2000, 4'h0, 16'h0, 32'h8000, "R3");
    apply(16'h6700, 16'h0100, 32'h2000, 4'h0, 16'h0, 32'h8000, "R3");
    apply(16'h6000, 16'h8000, 32'h00010000, 4'hF, 16'h0, 32'h8000, "R4");
    apply(16'h6110, 16'h0, 32'h3000, 4'h0, 16'h0, 32'h9000, "R5");
    apply(16'h6100, 16'h0040, 32'h3000, 4'h0, 16'h0, 32'h9000, "R5");
    apply(16'h51C9, 16'hFFFC, 32'h4000, 4'h0, 16'h0000, 32'h0, "R7");
    apply(16'h51C9, 16'hFFFC, 32'h4000, 4'h0, 16'h0001, 32'h0, "R7");
    apply(16'h51C9, 16'hFFFC, 32'h4000, 4'h0, 16'h8000, 32'h0, "R7");
    apply(16'h50C9, 16'hFFFC, 32'h4000, 4'h0, 16'h0005, 32'h0, "R8");
    apply(16'h4E71, 16'h1234, 32'h5000, 4'hF, 16'h0005, 32'h0, "R9");

    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "idle out_valid", 32'(out_valid), 32'd0);
    chk("R10", "idle taken", 32'(taken), 32'd0);

    for (int cc = 2; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        apply({4'h6, 4'(cc), 8'h10}, 16'h0, 32'h6000, 4'(f), 16'h0, 32'h0, "R1");
    for (int f = 0; f < 16; f++)
      for (int cc = 0; cc < 16; cc++)
        apply({4'h5, 4'(cc), 8'hC8}, 16'h0010, 32'h6000, 4'(f), 16'h0003, 32'h0, "R1");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] op;
      int kind;
      kind = $urandom_range(0, 2);
      op = 16'($urandom);
      if (kind == 0) op[15:12] = 4'h6;
      else if (kind == 1) begin op[15:12] = 4'h5; op[7:3] = 5'b11001; end
      else if (op[15:12] == 4'h5 || op[15:12] == 4'h6) op[15:12] = 4'h7;
      if (kind == 0 && $urandom_range(0, 3) == 0) op[7:0] = 8'h00;
      apply(op, 16'($urandom), {$urandom} & 32'hFFFF_FFFE, 4'($urandom),
            ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 1)) : 16'($urandom),
            $urandom & 32'hFFFF_FFFC, "");
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule